// File: doc/BRIEF.md
# Host-to-Peer Slot Mailbox

This block carries 32-bit slots between a host processor and an embedded peer controller. Each direction has its own circular buffer. The host reaches the block through a small 32-bit register bus with four word registers. Writing the outbound window queues one slot for the peer. Reading the inbound window takes one slot sent by the peer. The host also owns a control/status word and can read a mirror of the peer's control/status word.

Both status words share one layout. The low byte holds the interrupt enable, interrupt status, doorbell generate, ready and reset flags. Above the low byte sit the free-running 8-bit read and write pointers of one buffer, and the top byte gives the buffer depth in slots. Software gets the fill level by subtracting the pointers modulo 256. It gets the free space by subtracting the fill level from the depth.

The peer side is a plain slot interface. It has a pop port on the outbound buffer and a push port on the inbound buffer, together with level inputs for its enable, ready and reset flags. A one-cycle ring input sends a doorbell to the host, and an acknowledge input clears the doorbell the host sent. Each side has its own level interrupt output.

Top module: `slot_mailbox`

## Requirements
- R1: After reset, the word at byte offset 0x04 (host status) and the word at 0x0C (peer status) each read DEPTH<<24. Offset 0x00 reads zero, and both interrupt outputs are low.
- R2: A bus write to offset 0x00 appends the data to the outbound buffer. The peer pop port returns the slots in the order they were written, and each pop advances the outbound read pointer held in bits 15:8 of the host status word.
- R3: A write to 0x00 while the outbound buffer holds DEPTH slots is dropped and sets the sticky overflow flag at bit 5 of the host status word. Writing 1 to bit 5 clears the flag.
- R4: The pointers in bits 23:16 (write) and 15:8 (read) count freely through 255 and wrap to 0. The fill level equals write minus read modulo 256 and matches the fill output on the peer side. The free space equals the depth in bits 31:24 minus the fill level.
- R5: A read strobe at offset 0x08 returns the oldest inbound slot and advances the inbound read pointer in bits 15:8 of the peer status word. When the inbound buffer is empty, the read returns zero and the pointer stays where it is.
- R6: Writing 1 to bit 2 of the host status word sets the peer's interrupt status. Bit 2 reads 1 for exactly the cycle after the write and then clears by itself. The peer interrupt output is high while both the peer's enable and its status are 1, and peer acknowledge clears the status.
- R7: A peer ring pulse sets host status bit 1. The host interrupt output is high while bit 1 and enable bit 0 are both 1. Writing 1 to bit 1 clears it, and writing 0 to bit 1 leaves it set.
- R8: Setting host reset bit 4 clears both outbound pointers and host ready bit 3 at the edge of that write. While bit 4 is set, outbound writes are ignored. Likewise, the peer reset input clears both inbound pointers.
- R9: Bit 3 of the peer status word shows the peer ready input, masked off while the peer reset input is high. Bit 4 shows peer reset, and bit 0 shows the peer enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops the inbound window) |
| bus_rdata | output | 32 | Read data for bus_addr |
| host_irq | output | 1 | Interrupt to the host |
| peer_pop | input | 1 | Peer takes one outbound slot |
| peer_pop_data | output | 32 | Oldest outbound slot, zero when empty |
| peer_out_fill | output | 8 | Outbound fill level |
| peer_push | input | 1 | Peer adds one inbound slot |
| peer_push_data | input | 32 | Inbound slot data |
| peer_in_fill | output | 8 | Inbound fill level |
| peer_ie | input | 1 | Peer interrupt enable |
| peer_ready | input | 1 | Peer ready flag |
| peer_reset | input | 1 | Peer-side buffer reset |
| peer_ring | input | 1 | Doorbell pulse to the host |
| peer_ack | input | 1 | Clears the doorbell toward the peer |
| peer_irq | output | 1 | Interrupt to the peer |

## Verification
The bench pushes the outbound pointers past 255 while four slots are outstanding. A design that handles pointer wrap wrongly will then report a wrong fill level or stall. One write is aimed at a full buffer; a design that accepts it corrupts the oldest slot, which the scoreboard sees in the pop order. The bench reads the inbound window while it is empty, and a design that advances the pointer anyway would skew later reads. It also samples the doorbell bit in the cycle after the write and the cycle after that, so a bit that sticks or never shows is caught. Both reset paths are checked for clearing the pointers and ready while leaving stale slots unreachable.

// File: rtl/slot_mailbox.sv
module slot_mailbox #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        host_irq,
  input  logic        peer_pop,
  output logic [31:0] peer_pop_data,
  output logic [7:0]  peer_out_fill,
  input  logic        peer_push,
  input  logic [31:0] peer_push_data,
  output logic [7:0]  peer_in_fill,
  input  logic        peer_ie,
  input  logic        peer_ready,
  input  logic        peer_reset,
  input  logic        peer_ring,
  input  logic        peer_ack,
  output logic        peer_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic [31:0] out_mem [DEPTH];
  logic [31:0] in_mem [DEPTH];
  logic [7:0] out_wp, out_rp, in_wp, in_rp;
  logic h_ie, h_is, h_ig, h_rdy, h_rst, h_ovf, p_is;

  wire sel_out  = bus_addr[3:2] == 2'd0;
  wire sel_hcsr = bus_addr[3:2] == 2'd1;
  wire sel_in   = bus_addr[3:2] == 2'd2;
  wire csr_wr   = bus_wr && sel_hcsr;

  assign peer_out_fill = out_wp - out_rp;
  assign peer_in_fill  = in_wp - in_rp;

  wire out_full  = peer_out_fill == DEPTH8;
  wire host_push = bus_wr && sel_out && !h_rst;
  wire out_push  = host_push && !out_full;
  wire out_pop   = peer_pop && peer_out_fill != 8'd0 && !h_rst;
  wire out_clr   = h_rst || (csr_wr && bus_wdata[4]);
  wire in_push   = peer_push && !peer_reset && peer_in_fill != DEPTH8;
  wire in_avail  = peer_in_fill != 8'd0 && !peer_reset;
  wire in_pop    = bus_rd && sel_in && in_avail;

  always_ff @(posedge clk) begin
    if (!rst_n || out_clr) begin
      out_wp <= '0;
      out_rp <= '0;
    end else begin
      if (out_push) out_wp <= out_wp + 8'd1;
      if (out_pop)  out_rp <= out_rp + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || peer_reset) begin
      in_wp <= '0;
      in_rp <= '0;
    end else begin
      if (in_push) in_wp <= in_wp + 8'd1;
      if (in_pop)  in_rp <= in_rp + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (out_push) out_mem[out_wp[AW-1:0]] <= bus_wdata;
    if (in_push)  in_mem[in_wp[AW-1:0]] <= peer_push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {h_ie, h_is, h_ig, h_rdy, h_rst, h_ovf, p_is} <= '0;
    end else begin
      h_ig <= csr_wr && bus_wdata[2];
      if (csr_wr) begin
        h_ie  <= bus_wdata[0];
        h_rdy <= bus_wdata[3] && !bus_wdata[4];
        h_rst <= bus_wdata[4];
      end
      if (peer_ring) h_is <= 1'b1;
      else if (csr_wr && bus_wdata[1]) h_is <= 1'b0;
      if (host_push && out_full) h_ovf <= 1'b1;
      else if (csr_wr && bus_wdata[5]) h_ovf <= 1'b0;
      if (csr_wr && bus_wdata[2]) p_is <= 1'b1;
      else if (peer_ack) p_is <= 1'b0;
    end
  end

  wire [31:0] host_csr = {DEPTH8, out_wp, out_rp, 2'b00, h_ovf, h_rst, h_rdy, h_ig, h_is, h_ie};
  wire [31:0] peer_csr = {DEPTH8, in_wp, in_rp, 3'b000, peer_reset,
                          peer_ready && !peer_reset, peer_ring, p_is, peer_ie};

  always_comb begin
    case (bus_addr[3:2])
      2'd1:    bus_rdata = host_csr;
      2'd2:    bus_rdata = in_avail ? in_mem[in_rp[AW-1:0]] : 32'd0;
      2'd3:    bus_rdata = peer_csr;
      default: bus_rdata = 32'd0;
    endcase
  end

  assign peer_pop_data = (peer_out_fill != 8'd0 && !h_rst) ? out_mem[out_rp[AW-1:0]] : 32'd0;
  assign host_irq = h_ie && h_is;
  assign peer_irq = peer_ie && p_is;
endmodule

// File: rtl/slot_mailbox_chk.sv
module slot_mailbox_chk #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic        bus_rd,
  input logic        peer_ring,
  input logic        peer_reset,
  input logic [7:0]  peer_out_fill,
  input logic [7:0]  peer_in_fill,
  input logic        h_is,
  input logic        h_ig,
  input logic        h_rst,
  input logic        h_ovf,
  input logic [7:0]  in_rp
);
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    peer_out_fill <= 8'(DEPTH) && peer_in_fill <= 8'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd0 && peer_out_fill == 8'(DEPTH) && !h_rst) |=> h_ovf);

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[3:2] == 2'd2 && peer_in_fill == 8'd0 && !peer_reset) |=> $stable(in_rp));

  assert_gen_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_ig |=> !h_ig);

  assert_ring_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    peer_ring |=> h_is);

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_is && !(bus_wr && bus_addr[3:2] == 2'd1 && bus_wdata[1])) |=> h_is);

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    h_rst |=> peer_out_fill == 8'd0);
endmodule

bind slot_mailbox slot_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .peer_ring(peer_ring),
  .peer_reset(peer_reset), .peer_out_fill(peer_out_fill),
  .peer_in_fill(peer_in_fill), .h_is(h_is), .h_ig(h_ig), .h_rst(h_rst),
  .h_ovf(h_ovf), .in_rp(in_rp)
);

// File: tb/slot_mailbox_bench.sv
module slot_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, peer_pop_data, peer_push_data = 0;
  logic host_irq, peer_irq, peer_pop = 0, peer_push = 0;
  logic [7:0] peer_out_fill, peer_in_fill;
  logic peer_ie = 0, peer_ready = 0, peer_reset = 0, peer_ring = 0, peer_ack = 0;

  int ntests = 0, nfail = 0;
  logic [31:0] exp_out[$];
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_mailbox #(.DEPTH(DEPTH)) u_slot_mailbox (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(logic [3:0] a, logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic hr(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(logic [3:0] a, output logic [31:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic send(logic [31:0] v);
    hw(4'h0, v); exp_out.push_back(v);
  endtask

  task automatic ppop();
    @(negedge clk); peer_pop = 1;
    @(negedge clk); peer_pop = 0;
  endtask

  task automatic ppush(logic [31:0] v);
    @(negedge clk); peer_push = 1; peer_push_data = v;
    @(negedge clk); peer_push = 0;
  endtask

  // scoreboard monitor for the outbound path (R2)
  initial forever begin
    @(negedge clk); #(CLK_PERIOD/2 - 1);
    if (peer_pop && rst_n) begin
      if (exp_out.size() == 0) chk("R2 unexpected pop", {24'd0, peer_out_fill}, 32'd0);
      else chk("R2 pop order", peer_pop_data, exp_out.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    ntests++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(4'h4, d); chk("R1 host csr", d, 32'h0800_0000);
    peek(4'hC, d); chk("R1 peer csr", d, 32'h0800_0000);
    peek(4'h0, d); chk("R1 window", d, 0);
    chk("R1 irqs", {host_irq, peer_irq}, 0);

    for (int i = 0; i < 3; i++) send(32'hA000 + i);
    peek(4'h4, d); chk("R4 ptrs", d, 32'h0803_0000);
    chk("R4 fill out", {24'd0, peer_out_fill}, 3);
    repeat (3) ppop();
    peek(4'h4, d); chk("R2 read ptr", d, 32'h0803_0300);
    chk("R2 drained", exp_out.size(), 0);

    for (int i = 0; i < DEPTH; i++) send(32'hB000 + i);
    peek(4'h4, d); chk("R4 free", 32'(d[31:24] - 8'(d[23:16] - d[15:8])), 0);
    hw(4'h0, 32'hDEAD_BEEF);
    peek(4'h4, d); chk("R3 overflow flag", {31'd0, d[5]}, 1);
    chk("R3 wp held", {24'd0, d[23:16]}, 32'h0B);
    hw(4'h4, 32'h20);
    peek(4'h4, d); chk("R3 overflow clear", {31'd0, d[5]}, 0);
    repeat (DEPTH) ppop();
    chk("R3 drained", exp_out.size(), 0);

    for (int i = 0; i < 243; i++) begin send(i); ppop(); end
    for (int i = 0; i < 4; i++) send(32'hC000 + i);
    peek(4'h4, d); chk("R4 wrap ptrs", {16'd0, d[23:8]}, 32'h02FE);
    chk("R4 wrap fill", {24'd0, peer_out_fill}, 4);
    repeat (4) ppop();
    chk("R4 wrap drained", exp_out.size(), 0);

    hr(4'h8, d); chk("R5 empty read", d, 0);
    peek(4'hC, d); chk("R5 rp held", {24'd0, d[15:8]}, 0);
    ppush(32'h11); ppush(32'h22);
    peek(4'hC, d); chk("R5 in wp", {24'd0, d[23:16]}, 2);
    chk("R5 in fill", {24'd0, peer_in_fill}, 2);
    hr(4'h8, d); chk("R5 first", d, 32'h11);
    hr(4'h8, d); chk("R5 second", d, 32'h22);
    hr(4'h8, d); chk("R5 empty again", d, 0);
    peek(4'hC, d); chk("R5 rp", {24'd0, d[15:8]}, 2);

    peer_ie = 1;
    hw(4'h4, 32'h4);
    peek(4'h4, d); chk("R6 gen visible", {31'd0, d[2]}, 1);
    chk("R6 peer irq", {31'd0, peer_irq}, 1);
    @(negedge clk); peek(4'h4, d); chk("R6 gen self-clear", {31'd0, d[2]}, 0);
    peer_ack = 1; @(negedge clk); peer_ack = 0; #1;
    chk("R6 ack", {31'd0, peer_irq}, 0);

    hw(4'h4, 32'h1);
    peer_ring = 1; @(negedge clk); peer_ring = 0; #1;
    chk("R7 host irq", {31'd0, host_irq}, 1);
    hw(4'h4, 32'h1);
    peek(4'h4, d); chk("R7 w0 keeps", {31'd0, d[1]}, 1);
    hw(4'h4, 32'h3); #1;
    chk("R7 w1c", {31'd0, host_irq}, 0);
    peer_ring = 1; @(negedge clk); peer_ring = 0;
    hw(4'h4, 32'h0);
    peek(4'h4, d); chk("R7 masked status", {31'd0, d[1]}, 1);
    chk("R7 masked irq", {31'd0, host_irq}, 0);
    hw(4'h4, 32'h2);

    hw(4'h4, 32'h8);
    peek(4'h4, d); chk("R8 ready set", {31'd0, d[3]}, 1);
    send(32'hE1); send(32'hE2);
    hw(4'h4, 32'h18);
    peek(4'h4, d); chk("R8 flags", {27'd0, d[4:3]}, 32'b10);
    chk("R8 out ptrs", {16'd0, d[23:8]}, 0);
    exp_out.delete();
    hw(4'h0, 32'hE3);
    peek(4'h4, d); chk("R8 ignored write", {24'd0, d[23:16]}, 0);
    hw(4'h4, 32'h8);
    peek(4'h4, d); chk("R8 release", {27'd0, d[4:3]}, 32'b01);

    ppush(32'h33); peer_ready = 1; #1;
    peek(4'hC, d); chk("R9 ready", {31'd0, d[3]}, 1);
    chk("R9 enable", {31'd0, d[0]}, 1);
    @(negedge clk); peer_reset = 1; @(negedge clk);
    peek(4'hC, d); chk("R9 ready masked", {27'd0, d[4:3]}, 32'b10);
    chk("R8 in ptrs", {16'd0, d[23:8]}, 0);
    peer_reset = 0; #1;
    peek(4'hC, d); chk("R9 ready back", {31'd0, d[3]}, 1);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule